// File: doc/BRIEF.md
# Oversampled SPI Slave

This block is an SPI slave that runs entirely on the system clock. The serial clock, data-in and select pins are treated as ordinary inputs. Each passes through a two-stage synchronizer. A serial clock edge is found by comparing the synchronized sample with the one taken a cycle earlier. Because of this, each high and each low phase of the serial clock must last more than two system-clock cycles.

The bus uses mode 0. The master's data is captured on each detected rising edge. The next outgoing bit is presented on each detected falling edge, most significant bit first. When select falls, the first outgoing bit appears before any clock edge arrives.

Software writes a transmit holding register at any time. Its contents are copied into the shifter at selection and again at every byte boundary. After eight rising edges the received byte is copied into a buffer register and a completion flag is set. The flag stays set until it is cleared. When select goes high, the bit counter and the partial receive shifter are cleared. Any incomplete byte is lost, and the serial data output is released.

Top module: `spi_oversampled_slave`

## Requirements
- R1: After reset, misoOe is 0, doneFlag is 0 and rxData is 0x00.
- R2: While ssPin is high, misoOe is 0 and serial clock pulses change neither rxData nor doneFlag.
- R3: During a selected transfer, the byte in the transmit holding register is driven on misoOut most significant bit first. The 8 bits on mosiPin, also MSB first, appear in rxData once the 8th rising edge has been taken.
- R4: doneFlag rises only after the 8th rising edge of a byte and stays 0 after seven.
- R5: A one-cycle flagClear pulse returns doneFlag to 0 and leaves rxData unchanged.
- R6: Within a single selection, consecutive bytes are exchanged without deselecting. The byte written to the holding register during the first byte is sent as the second byte.
- R7: Raising ssPin in the middle of a byte discards the partial bits: doneFlag stays 0, rxData keeps its old value, and the next selection starts counting again at bit 0.
- R8: While selected, misoOe equals misoEnable.
- R9: Writes to the holding register while deselected are allowed, and the last write before selection is the byte that is sent.
- R10: A few cycles after ssPin falls, and before any serial clock edge, misoOut shows bit 7 of the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckPin | input | 1 | Serial clock from the master (sampled) |
| mosiPin | input | 1 | Serial data from the master |
| ssPin | input | 1 | Active-low select |
| misoEnable | input | 1 | User setting that allows the data output to be driven |
| txData | input | 8 | Byte written to the transmit holding register |
| txLoad | input | 1 | Write strobe for txData |
| flagClear | input | 1 | Clears the completion flag |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for misoOut (0 = tri-stated) |
| rxData | output | 8 | Last complete received byte |
| doneFlag | output | 1 | Byte-complete flag |

## Verification
Transfers use alternating patterns (0xA5, 0x5A), all-ones and all-zeros, and bytes whose only set bits are at the edges (0x81). Together these separate bit-order errors, stuck shifter bits and missing end bits. A run of seven clock pulses followed by an eighth shows whether the flag arrives one edge early or late. An abort after five bits, followed by a fresh byte, shows whether the counter and partial shifter are really cleared. Two bytes inside one selection show whether the reload at the byte boundary takes the updated holding value.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic clearAll;   // slave deselected: drop partial state
    logic startLoad;  // selection began: copy holding reg to shifter
    logic sampleIn;   // rising edge: shift in one data bit
    logic shiftOut;   // falling edge inside a byte: advance output
    logic nextLoad;   // falling edge at byte boundary: reload shifter
    logic byteDone;   // last bit of a byte was sampled
  } ctrlStrobes_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= RESET_VAL;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RESET_VAL;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckS,
  input  logic             ssS,
  output ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] bitCount,
  output logic             selected
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic sckPrev, ssPrev;
  logic riseDet, fallDet;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      ssPrev  <= 1'b1;
    end else begin
      sckPrev <= sckS;
      ssPrev  <= ssS;
    end
  end

  always_comb begin
    selected = ~ssS;
    riseDet  = selected & sckS & ~sckPrev;
    fallDet  = selected & ~sckS & sckPrev;
    strobes.clearAll  = ssS;
    strobes.startLoad = selected & ssPrev;
    strobes.sampleIn  = riseDet;
    strobes.byteDone  = riseDet & (bitCnt == LAST_BIT);
    strobes.shiftOut  = fallDet & (bitCnt != '0);
    strobes.nextLoad  = fallDet & (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bitCnt <= '0;
    else if (ssS)         bitCnt <= '0;
    else if (riseDet)     bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  assign bitCount = bitCnt;
endmodule

// File: rtl/spi_slv_datapath.sv
module spi_slv_datapath
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLoad,
  input  logic              flagClear,
  output logic              misoBit,
  output logic [DATA_W-1:0] txHold,
  output logic [DATA_W-1:0] rxBuffer,
  output logic              doneFlag
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxShift[DATA_W-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       txHold <= '0;
    else if (txLoad) txHold <= txData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   txShift <= '0;
    else if (strobes.startLoad || strobes.nextLoad) txShift <= txHold;
    else if (strobes.shiftOut)                   txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxShift <= '0;
    else if (strobes.clearAll) rxShift <= '0;
    else if (strobes.sampleIn) rxShift <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxBuffer <= '0;
    else if (strobes.byteDone) rxBuffer <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 doneFlag <= 1'b0;
    else if (strobes.byteDone) doneFlag <= 1'b1;
    else if (flagClear)        doneFlag <= 1'b0;
  end

  assign misoBit = txShift[DATA_W-1];
endmodule

// File: rtl/spi_oversampled_slave.sv
module spi_oversampled_slave
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckPin,
  input  logic              mosiPin,
  input  logic              ssPin,
  input  logic              misoEnable,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLoad,
  input  logic              flagClear,
  output logic              misoOut,
  output logic              misoOe,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag
);
  logic [2:0]        pinSync;
  logic              sckSync, mosiSync, ssSync;
  logic              selected;
  ctrlStrobes_t      strobes;
  logic [CNT_W-1:0]  bitCount;
  logic [DATA_W-1:0] txHold;
  logic              misoBit;

  spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({ssPin, mosiPin, sckPin}),
    .syncOut(pinSync)
  );
  assign {ssSync, mosiSync, sckSync} = pinSync;

  spi_slv_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .sckS(sckSync), .ssS(ssSync),
    .strobes(strobes), .bitCount(bitCount), .selected(selected)
  );

  spi_slv_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .mosiS(mosiSync),
    .txData(txData), .txLoad(txLoad), .flagClear(flagClear),
    .misoBit(misoBit), .txHold(txHold),
    .rxBuffer(rxData), .doneFlag(doneFlag)
  );

  assign misoOut = misoBit;
  assign misoOe  = selected & misoEnable;
endmodule

// File: rtl/spi_slave_checks.sv
module spi_slave_checks
  import spi_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ssSync,
  input logic [DATA_W-1:0] rxData,
  input logic              doneFlag,
  input logic              flagClear,
  input ctrlStrobes_t      strobes,
  input logic [CNT_W-1:0]  bitCount,
  input logic              misoOut,
  input logic [DATA_W-1:0] txHold
);
  assert_rx_stable_deselected_R2: assert property (@(posedge clk) disable iff (!rstN)
    ssSync |=> $stable(rxData));

  assert_flag_after_last_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(bitCount) == CNT_W'(DATA_W - 1));

  assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !strobes.byteDone) |=> !doneFlag);

  assert_counter_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    ssSync |=> bitCount == '0);

  assert_first_bit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssSync) |=> misoOut == $past(txHold[DATA_W-1]));
endmodule

bind spi_oversampled_slave spi_slave_checks #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_checks (
  .clk(clk), .rstN(rstN), .ssSync(ssSync), .rxData(rxData),
  .doneFlag(doneFlag), .flagClear(flagClear), .strobes(strobes),
  .bitCount(bitCount), .misoOut(misoOut), .txHold(txHold)
);

// File: tb/test_spi_oversampled_slave.sv
module test_spi_oversampled_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckPin = 1'b0, mosiPin = 1'b0, ssPin = 1'b1, misoEnable = 1'b1;
  logic [7:0] txData = 8'h00;
  logic txLoad = 1'b0, flagClear = 1'b0;
  logic misoOut, misoOe, doneFlag;
  logic [7:0] rxData;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  spi_oversampled_slave i_spi_oversampled_slave (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .mosiPin(mosiPin), .ssPin(ssPin),
    .misoEnable(misoEnable), .txData(txData), .txLoad(txLoad), .flagClear(flagClear),
    .misoOut(misoOut), .misoOe(misoOe), .rxData(rxData), .doneFlag(doneFlag)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic loadTx(input logic [7:0] v);
    txData = v; txLoad = 1'b1; tick(1); txLoad = 1'b0;
  endtask

  task automatic clearFlag();
    flagClear = 1'b1; tick(1); flagClear = 1'b0; tick(1);
  endtask

  task automatic selectSlave();
    ssPin = 1'b0; tick(4);
  endtask

  task automatic deselectSlave();
    ssPin = 1'b1; tick(4);
  endtask

  // master side of mode 0: nBits bits, MSB first; returns bits seen on misoOut
  task automatic xferBits(input logic [7:0] mOut, input int nBits, output logic [7:0] sIn);
    sIn = 8'h00;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosiPin = mOut[i];
      tick(4);
      sIn[i] = misoOut;
      sckPin = 1'b1;
      tick(4);
      sckPin = 1'b0;
    end
    tick(1);
  endtask

  task automatic t_reset();
    check(misoOe == 1'b0, "R1 oe", misoOe, 0);
    check(doneFlag == 1'b0, "R1 flag", doneFlag, 0);
    check(rxData == 8'h00, "R1 rx", rxData, 0);
  endtask

  task automatic t_idleIgnored();
    misoEnable = 1'b1;
    tick(4);
    check(misoOe == 1'b0, "R2 oe while deselected", misoOe, 0);
    for (int i = 0; i < 10; i++) begin
      sckPin = 1'b1; mosiPin = 1'b1; tick(4);
      sckPin = 1'b0; tick(4);
    end
    check(doneFlag == 1'b0, "R2 flag unchanged", doneFlag, 0);
    check(rxData == 8'h00, "R2 rx unchanged", rxData, 0);
  endtask

  task automatic t_singleByte();
    logic [7:0] got;
    loadTx(8'h11);
    loadTx(8'hA5);  // R9: last write while deselected wins
    selectSlave();
    check(misoOut == 1'b1, "R10 first bit before clock", misoOut, 1);
    check(misoOe == 1'b1, "R8 oe while selected", misoOe, 1);
    xferBits(8'h3C, 8, got);
    check(got == 8'hA5, "R3/R9 byte sent", got, 8'hA5);
    check(rxData == 8'h3C, "R3 byte received", rxData, 8'h3C);
    check(doneFlag == 1'b1, "R3 flag set", doneFlag, 1);
    deselectSlave();
  endtask

  task automatic t_flagClear();
    clearFlag();
    check(doneFlag == 1'b0, "R5 flag cleared", doneFlag, 0);
    check(rxData == 8'h3C, "R5 rx kept", rxData, 8'h3C);
  endtask

  task automatic t_flagTiming();
    logic [7:0] got;
    logic [7:0] rest;
    loadTx(8'h00);
    selectSlave();
    xferBits(8'hFF, 7, got);
    tick(4);
    check(doneFlag == 1'b0, "R4 no flag after seven", doneFlag, 0);
    mosiPin = 1'b1; tick(4);
    rest = {7'b0, misoOut};
    sckPin = 1'b1; tick(4); sckPin = 1'b0; tick(1);
    check(doneFlag == 1'b1, "R4 flag after eighth", doneFlag, 1);
    check(rxData == 8'hFF, "R4 rx all ones", rxData, 8'hFF);
    check({got[7:1], rest[0]} == 8'h00, "R3 all zeros sent", {got[7:1], rest[0]}, 0);
    deselectSlave();
    clearFlag();
  endtask

  task automatic t_partialDrop();
    logic [7:0] got;
    loadTx(8'hFF);
    selectSlave();
    xferBits(8'h00, 5, got);
    deselectSlave();
    check(doneFlag == 1'b0, "R7 no flag on abort", doneFlag, 0);
    check(rxData == 8'hFF, "R7 rx kept on abort", rxData, 8'hFF);
    selectSlave();
    xferBits(8'h81, 8, got);
    check(rxData == 8'h81, "R7 fresh byte after abort", rxData, 8'h81);
    check(got == 8'hFF, "R7 shifter reloaded", got, 8'hFF);
    check(doneFlag == 1'b1, "R7 flag on fresh byte", doneFlag, 1);
    deselectSlave();
    clearFlag();
  endtask

  task automatic t_backToBack();
    logic [7:0] got;
    loadTx(8'hC3);
    selectSlave();
    loadTx(8'h96);
    xferBits(8'h5A, 8, got);
    check(got == 8'hC3, "R6 first byte sent", got, 8'hC3);
    check(rxData == 8'h5A, "R6 first byte received", rxData, 8'h5A);
    xferBits(8'h24, 8, got);
    check(got == 8'h96, "R6 second byte sent", got, 8'h96);
    check(rxData == 8'h24, "R6 second byte received", rxData, 8'h24);
    deselectSlave();
    clearFlag();
  endtask

  task automatic t_oeControl();
    misoEnable = 1'b0;
    selectSlave();
    check(misoOe == 1'b0, "R8 oe off when disabled", misoOe, 0);
    misoEnable = 1'b1; tick(1);
    check(misoOe == 1'b1, "R8 oe on when enabled", misoOe, 1);
    deselectSlave();
    check(misoOe == 1'b0, "R2 oe released on deselect", misoOe, 0);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    t_reset();
    t_idleIgnored();
    t_singleByte();
    t_flagClear();
    t_flagTiming();
    t_partialDrop();
    t_backToBack();
    t_oeControl();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule